// File: doc/BRIEF.md
# Justification Destuffing Demultiplexer

This block sits behind a frame aligner on the receive side of a bit-interleaved multiplex. The aligner hands it one tributary's share of the aggregate, one bit at a time, and tags each bit with a slot kind. The kinds are an ordinary payload bit, a justification control bit, or the single opportunity slot that may carry either a tributary bit or a filler bit. The block counts the control bits of the current frame and takes a majority decision on them. It then loads only genuine tributary bits into an elastic buffer.

A downstream consumer drains the buffer with a read strobe at the smoothed tributary rate. The buffer occupancy is presented every cycle, so that an external clock-smoothing loop can steer that rate. A control pattern that disagrees with itself but still has a clear majority is accepted. It is also reported with a one-cycle correctable-error pulse.

Top module: `jdm_top`

## Requirements
- R1: After reset, `fill` is 0, `underflow` is 0, `rd_data` is 0 and `corr_err` is 0.
- R2: Every accepted bit of kind payload (`in_kind`=0) is stored. Stored bits come out on `rd_data` in arrival order, one per read strobe, in the cycle after the strobe.
- R3: Bits of kind control (`in_kind`=1) never enter the buffer. They only feed the vote.
- R4: At an opportunity bit (`in_kind`=2), the control bits since the previous opportunity are voted. If more than half of `CTRL_BITS` are 1 the slot is filler and is discarded. Otherwise the slot bit is stored as tributary data.
- R5: If the control bits voted at an opportunity slot are neither all 0 nor all 1, `corr_err` is high for exactly the cycle after that slot. A unanimous pattern leaves it low.
- R6: `fill` equals the stored bits minus the bits read, ranges from 0 to `DEPTH`, and is updated one cycle after the write or read. A simultaneous write and read of a non-empty buffer leave it unchanged.
- R7: A write into a full buffer is discarded. `fill` stays at `DEPTH` and the stored bits are kept.
- R8: A read strobe on an empty buffer sets `underflow`, which stays set until reset. `rd_data` keeps its previous value.
- R9: Inputs with `in_valid` low, or with `in_kind`=3, change neither the buffer nor the vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_bit` and `in_kind` |
| in_kind | input | 2 | Slot kind: 0 payload, 1 control, 2 opportunity, 3 reserved |
| in_bit | input | 1 | Received bit of the tributary share |
| rd_en | input | 1 | Read strobe at the smoothed tributary rate |
| rd_data | output | 1 | Tributary bit read out, registered |
| fill | output | $clog2(DEPTH+1) | Buffer occupancy in bits |
| underflow | output | 1 | Sticky: a read was attempted on an empty buffer |
| corr_err | output | 1 | One-cycle pulse: a mixed control pattern was outvoted |

## Verification
The bench sends frames with unanimous and mixed control patterns of both polarities. A design that inverts the vote, or counts a minority as the decision, would either store filler bits or lose data bits, and the fill count and the read-out sequence would then disagree with the model. The bench checks that control bits and reserved or unqualified slots leave the fill level unchanged. It drives the buffer past full and reads it while empty, so that a design that overwrites stored data, moves `rd_data` on an empty read, or clears the underflow flag shows a wrong bit or flag. It also checks that the correctable-error pulse lasts one cycle, which exposes a level held too long or raised on a clean pattern.

// File: rtl/jdm_pkg.sv
package jdm_pkg;

  typedef enum logic [1:0] {
    SLOT_PAY = 2'd0,
    SLOT_CTL = 2'd1,
    SLOT_OPP = 2'd2,
    SLOT_RSV = 2'd3
  } slot_kind_e;

  // Majority decision: true means the opportunity slot holds filler.
  function automatic logic vote_is_stuff(input int ones, input int nbits);
    return (2 * ones) > nbits;
  endfunction

  // A pattern that is neither all zeros nor all ones among those seen.
  function automatic logic vote_is_mixed(input int ones, input int seen);
    return (ones != 0) && (ones != seen);
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int fill_after(input int cur, input logic push, input logic pop);
    return cur + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/jdm_vote.sv
module jdm_vote #(
  parameter int CTRL_BITS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_fire,
  input  logic ctl_bit,
  input  logic opp_fire,
  output logic dec_stuff,
  output logic dec_mixed
);
  import jdm_pkg::*;

  localparam int CNT_W = $clog2(CTRL_BITS + 1);

  logic [CNT_W-1:0] ones_q;
  logic [CNT_W-1:0] seen_q;
  logic             room;

  assign room = (int'(seen_q) < CTRL_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0;
      seen_q <= '0;
    end else if (opp_fire) begin
      ones_q <= '0;
      seen_q <= '0;
    end else if (ctl_fire && room) begin
      seen_q <= seen_q + 1'b1;
      if (ctl_bit) ones_q <= ones_q + 1'b1;
    end
  end

  always_comb begin
    dec_stuff = vote_is_stuff(int'(ones_q), CTRL_BITS);
    dec_mixed = vote_is_mixed(int'(ones_q), int'(seen_q));
  end

  // R4: the tally never exceeds the code length
  a_r4_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(seen_q) <= CTRL_BITS) && (ones_q <= seen_q));

  // R4: an opportunity slot restarts the tally
  a_r4_tally_restart: assert property (@(posedge clk) disable iff (!rst_n)
    opp_fire |=> (seen_q == '0 && ones_q == '0));

endmodule

// File: rtl/jdm_fifo.sv
module jdm_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_bit,
  input  logic                       rd_en,
  output logic                       rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       underflow,
  output logic                       push,
  output logic                       pop
);
  import jdm_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          empty, full;

  assign empty = (fill == '0);
  assign full  = (int'(fill) == DEPTH);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      fill      <= '0;
      rd_data   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop) begin
        rptr    <= ptr_next(rptr);
        rd_data <= mem[rptr];
      end
      if (rd_en && empty) underflow <= 1'b1;
      fill <= CW'(fill_after(int'(fill), push, pop));
    end
  end

  // R6: occupancy stays within the buffer
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  // R7: a write into a full buffer without a read leaves it full
  a_r7_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (int'(fill) == DEPTH));

  // R8: underflow is sticky
  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R8: an empty read holds the output
  a_r8_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> ($stable(rd_data) && underflow));

endmodule

// File: rtl/jdm_top.sv
module jdm_top #(
  parameter int CTRL_BITS = 3,
  parameter int DEPTH     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 in_kind,
  input  logic                       in_bit,
  input  logic                       rd_en,
  output logic                       rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       underflow,
  output logic                       corr_err
);
  import jdm_pkg::*;

  slot_kind_e kind;
  logic pay_fire, ctl_fire, opp_fire;
  logic dec_stuff, dec_mixed;
  logic wr_en, push, pop;

  assign kind     = slot_kind_e'(in_kind);
  assign pay_fire = in_valid && (kind == SLOT_PAY);
  assign ctl_fire = in_valid && (kind == SLOT_CTL);
  assign opp_fire = in_valid && (kind == SLOT_OPP);

  jdm_vote #(.CTRL_BITS(CTRL_BITS)) u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_fire  (ctl_fire),
    .ctl_bit   (in_bit),
    .opp_fire  (opp_fire),
    .dec_stuff (dec_stuff),
    .dec_mixed (dec_mixed)
  );

  assign wr_en = pay_fire || (opp_fire && !dec_stuff);

  jdm_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_bit    (in_bit),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .fill      (fill),
    .underflow (underflow),
    .push      (push),
    .pop       (pop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) corr_err <= 1'b0;
    else        corr_err <= opp_fire && dec_mixed;
  end

  // R3: a control bit does not grow the buffer
  a_r3_ctl_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fire && !pop) |=> (fill == $past(fill)));

  // R4: a filler slot does not grow the buffer
  a_r4_stuff_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (opp_fire && dec_stuff && !pop) |=> (fill == $past(fill)));

  // R5: the correctable-error pulse only follows an opportunity slot
  a_r5_pulse_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
    corr_err |-> $past(opp_fire));

  // R9: reserved or unqualified inputs write nothing
  a_r9_idle_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (!pay_fire && !opp_fire) |-> !push);

endmodule

// File: tb/sim_jdm_top.sv
module sim_jdm_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic in_bit = 1'b0;
  logic rd_en = 1'b0;
  logic rd_data;
  logic [CW-1:0] fill;
  logic underflow;
  logic corr_err;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_q[$];
  logic last_rd = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jdm_top #(.CTRL_BITS(3), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_bit(in_bit), .rd_en(rd_en), .rd_data(rd_data), .fill(fill),
    .underflow(underflow), .corr_err(corr_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one input cycle; returns at the next falling edge with outputs settled
  task automatic send(input logic v, input logic [1:0] k, input logic b);
    @(negedge clk);
    in_valid = v; in_kind = k; in_bit = b;
    @(negedge clk);
    in_valid = 1'b0;
    if (v && (k == 2'd0) && exp_q.size() < DEPTH) exp_q.push_back(b);
  endtask

  task automatic frame(input logic [2:0] ctl, input logic opp, output logic stuffed);
    int ones = 0;
    for (int i = 0; i < 3; i++) begin
      send(1'b1, 2'd1, ctl[i]);
      ones += ctl[i];
    end
    stuffed = (2 * ones > 3);
    send(1'b1, 2'd2, opp);
    if (!stuffed && exp_q.size() < DEPTH) exp_q.push_back(opp);
  endtask

  task automatic read_one(input string tag);
    bit e;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    e = exp_q.pop_front();
    check(tag, int'(rd_data), int'(e));
    last_rd = rd_data;
  endtask

  task automatic t_reset;
    check("R1 fill", int'(fill), 0);
    check("R1 underflow", int'(underflow), 0);
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 corr_err", int'(corr_err), 0);
  endtask

  task automatic t_clean_frames;
    logic st;
    send(1, 0, 1); send(1, 0, 0); send(1, 0, 1); send(1, 0, 1);
    check("R2 fill after payload", int'(fill), 4);
    for (int i = 0; i < 3; i++) send(1, 1, 0);
    check("R3 control not stored", int'(fill), 4);
    send(1, 2, 1);
    check("R4 data slot stored", int'(fill), 5);
    check("R5 no pulse on 000", int'(corr_err), 0);
    exp_q.push_back(1'b1);
    frame(3'b111, 1'b0, st);
    check("R4 stuff slot dropped", int'(fill), 5);
    check("R5 no pulse on 111", int'(corr_err), 0);
  endtask

  task automatic t_mixed_frames;
    logic st;
    frame(3'b011, 1'b1, st);
    check("R4 110 votes stuff", int'(fill), 5);
    check("R5 pulse on mixed stuff", int'(corr_err), 1);
    send(0, 0, 0);
    check("R5 pulse lasts one cycle", int'(corr_err), 0);
    frame(3'b100, 1'b0, st);
    check("R4 001 votes data", int'(fill), 6);
    check("R5 pulse on mixed data", int'(corr_err), 1);
  endtask

  task automatic t_ignored;
    send(1, 3, 1);
    send(0, 0, 1);
    send(0, 2, 1);
    check("R9 ignored inputs", int'(fill), 6);
  endtask

  task automatic t_simul;
    @(negedge clk);
    in_valid = 1; in_kind = 0; in_bit = 0; rd_en = 1;
    @(negedge clk);
    in_valid = 0; rd_en = 0;
    exp_q.push_back(1'b0);
    check("R6 push+pop keeps fill", int'(fill), 6);
    last_rd = rd_data;
    check("R2 simultaneous read", int'(rd_data), int'(exp_q.pop_front()));
  endtask

  task automatic t_drain_underflow;
    int n = exp_q.size();
    for (int i = 0; i < n; i++) begin
      read_one("R2 read order");
      check("R6 fill after read", int'(fill), n - 1 - i);
    end
    check("R8 no underflow yet", int'(underflow), 0);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    check("R8 underflow set", int'(underflow), 1);
    check("R8 rd_data held", int'(rd_data), int'(last_rd));
    check("R6 fill stays 0", int'(fill), 0);
    send(1, 0, 1);
    check("R8 underflow sticky", int'(underflow), 1);
    read_one("R2 read after underflow");
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH + 3; i++) send(1, 0, logic'((i * 5 + 1) % 3 == 0));
    check("R7 fill capped", int'(fill), DEPTH);
    for (int i = 0; i < DEPTH; i++) read_one("R7 stored bits kept");
    check("R6 empty after drain", int'(fill), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_frames();
    t_mixed_frames();
    t_ignored();
    t_simul();
    t_drain_underflow();
    t_full();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule